// File: doc/BRIEF.md
# Indexed Display Adapter Register Port

This block is the host-facing control register file of a simple display adapter. The host reaches every register through two narrow ports. It first writes a register number to the selector port. It then reads or writes the chosen register through the data port. A third port is present for firmware compatibility only: it accepts writes and reads as zero.

The block holds the adapter identity, the enable and ring-configured flags, the pending display mode, cursor state, a guest identifier and a small bank of scratch words. Most other reads are computed on the fly from parameters and from the mode registers. These include pixel size, line pitch, framebuffer size, memory window geometry, capability bits and mode limits. Writes are filtered by value. The identity register takes only three legal codes, the colour depth cannot be changed, and the cursor control is a small state encoding. A one-cycle strobe tells a separate command-ring checker that the host has declared its ring configured.

Top module: `disp_regport`

## Requirements
- R1: After reset the selector reads 0, the identity register reads 0x90000002, and the enable, ring-configured and cursor-visible outputs are low.
- R2: A data write to register 0 (identity) is taken only for 0x90000000, 0x90000001 or 0x90000002. Any other value leaves the register unchanged.
- R3: Registers 7 and 28 read the colour depth rounded up to a multiple of 8 (24 for the default depth 24). A write to register 7 has no effect on any read value.
- R4: Register 12 reads ceil(depth/8) times the pending width (register 2). Register 16 reads ceil(depth/8) times width times height, recomputed when register 1, 2 or 3 is written.
- R5: Register 4 reads 2360 and register 5 reads 1770.
- R6: Register 17 (capabilities) always has bits 0 and 1 set. Bits 5, 6 and 7 are set exactly when `cursor_sink` is high. All other bits are zero.
- R7: Register 19 reads 0x10000. Register 18 reads the memory base plus the memory size minus 0x10000. Register 15 reads the memory size minus 0x10000.
- R8: Writing register 1 sets `disp_enable` to (value != 0). A zero value also clears `ring_config`. A nonzero value leaves `ring_config` unchanged.
- R9: Writing register 20 sets `ring_config` to (value != 0). A nonzero value raises `cfg_done` for exactly the cycle after the write.
- R10: A write to register 27 with value 1 sets `cursor_on` and with value 0 clears it. Either of these pulses `cursor_evt` for one cycle. Any other value changes neither `cursor_on` nor `cursor_evt`. Register 25 drives `cursor_x`.
- R11: Register 29 reads the scratch count (16). Registers 1792 to 1792+count-1 are read/write scratch words. Register 23 (guest id) reads back what was written.
- R12: A data-port read of a register outside 0..32, 1024..1791 and the scratch range returns zero with `rsp_bad` high. A read of 1024..1791 returns zero with `rsp_bad` low. The firmware port (port 2) reads zero and its writes change nothing.
- R13: A read request produces `rsp_valid` with data exactly one cycle later and for one cycle only. `req_ready` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | STRIDE_LOG2+2 | Port offset: 0 selector, 1 data, 2 firmware (scaled by 2^STRIDE_LOG2) |
| req_wdata | input | 32 | Write data |
| cursor_sink | input | 1 | A hardware cursor consumer is attached |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| rsp_bad | output | 1 | Read hit an undefined register |
| disp_enable | output | 1 | Display enabled |
| ring_config | output | 1 | Command ring declared configured |
| cfg_done | output | 1 | One-cycle strobe on a nonzero configure write |
| cursor_evt | output | 1 | One-cycle strobe on a show or hide cursor write |
| cursor_on | output | 1 | Cursor visible |
| cursor_x | output | 32 | Cursor X position |
| cursor_y | output | 32 | Cursor Y position |

## Verification
The assertions assume at most one request per cycle and a `req_write` that is defined whenever `req_valid` is high. They also assume that the host holds no request across reset release. The bench drives each request for exactly one cycle between falling edges. It returns `req_valid` low before the next request, and it keeps every request at least one clock clear of reset release. Because strobe checks compare against the previous cycle's request data, `req_wdata` is only sampled in the cycle of its own request.

// File: rtl/disp_regport.sv
module disp_regport #(
  parameter int          STRIDE_LOG2 = 0,
  parameter int          DEPTH       = 24,
  parameter int          MAX_W       = 2360,
  parameter int          MAX_H       = 1770,
  parameter logic [31:0] MEM_BASE    = 32'hE000_0000,
  parameter logic [31:0] MEM_BYTES   = 32'h0100_0000,
  parameter logic [31:0] RING_BYTES  = 32'h0001_0000,
  parameter int          SCRATCH_N   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [STRIDE_LOG2+1:0] req_addr,
  input  logic [31:0]            req_wdata,
  input  logic                   cursor_sink,
  output logic                   rsp_valid,
  output logic [31:0]            rsp_rdata,
  output logic                   rsp_bad,
  output logic                   disp_enable,
  output logic                   ring_config,
  output logic                   cfg_done,
  output logic                   cursor_evt,
  output logic                   cursor_on,
  output logic [31:0]            cursor_x,
  output logic [31:0]            cursor_y
);
  localparam int          BYPP   = (DEPTH + 7) / 8;
  localparam logic [31:0] BPP    = 32'(BYPP * 8);
  localparam logic [31:0] BYPP32 = 32'(BYPP);
  localparam int          SW     = (SCRATCH_N > 1) ? $clog2(SCRATCH_N) : 1;
  localparam logic [31:0] MAGIC  = 32'h9000_0000;

  localparam logic [31:0] I_ID = 0, I_EN = 1, I_W = 2, I_H = 3, I_MAXW = 4, I_MAXH = 5;
  localparam logic [31:0] I_DEPTH = 6, I_BPP = 7, I_BPL = 12, I_VSZ = 15, I_FBSZ = 16;
  localparam logic [31:0] I_CAPS = 17, I_MSTART = 18, I_MSZ = 19, I_CFG = 20, I_GUEST = 23;
  localparam logic [31:0] I_CID = 24, I_CX = 25, I_CY = 26, I_CON = 27, I_HBPP = 28, I_SCN = 29;
  localparam logic [31:0] I_LAST = 32, PAL_LO = 1024, PAL_HI = 1791, SCR_LO = 1792;
  localparam logic [31:0] SCR_HI = SCR_LO + 32'(SCRATCH_N) - 1;

  logic [31:0] index_q, id_q, width_q, height_q, fb_q, guest_q, cur_id_q;
  logic [31:0] scr_q [SCRATCH_N];
  logic [31:0] val_mux, w_nxt, h_nxt;
  logic [1:0]  psel;
  logic        rd, wr_idx, wr_val, in_pal, in_scr, known;
  logic [SW-1:0] sidx;

  assign req_ready = 1'b1;
  assign psel   = req_addr[STRIDE_LOG2 +: 2];
  assign rd     = req_valid && !req_write;
  assign wr_idx = req_valid && req_write && psel == 2'd0;
  assign wr_val = req_valid && req_write && psel == 2'd1;
  assign in_pal = index_q >= PAL_LO && index_q <= PAL_HI;
  assign in_scr = index_q >= SCR_LO && index_q <= SCR_HI;
  assign known  = index_q <= I_LAST;
  assign sidx   = SW'(index_q - SCR_LO);
  assign w_nxt  = (wr_val && index_q == I_W) ? req_wdata : width_q;
  assign h_nxt  = (wr_val && index_q == I_H) ? req_wdata : height_q;

  always_comb begin
    case (index_q)
      I_ID:          val_mux = id_q;
      I_EN:          val_mux = {31'd0, disp_enable};
      I_W:           val_mux = width_q;
      I_H:           val_mux = height_q;
      I_MAXW:        val_mux = 32'(MAX_W);
      I_MAXH:        val_mux = 32'(MAX_H);
      I_DEPTH:       val_mux = 32'(DEPTH);
      I_BPP, I_HBPP: val_mux = BPP;
      I_BPL:         val_mux = BYPP32 * width_q;
      I_VSZ:         val_mux = MEM_BYTES - RING_BYTES;
      I_FBSZ:        val_mux = fb_q;
      I_CAPS:        val_mux = {24'd0, {3{cursor_sink}}, 3'd0, 2'b11};
      I_MSTART:      val_mux = MEM_BASE + MEM_BYTES - RING_BYTES;
      I_MSZ:         val_mux = RING_BYTES;
      I_CFG:         val_mux = {31'd0, ring_config};
      I_GUEST:       val_mux = guest_q;
      I_CID:         val_mux = cur_id_q;
      I_CX:          val_mux = cursor_x;
      I_CY:          val_mux = cursor_y;
      I_CON:         val_mux = {31'd0, cursor_on};
      I_SCN:         val_mux = 32'(SCRATCH_N);
      default:       val_mux = in_scr ? scr_q[sidx] : 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= '0; id_q <= MAGIC | 32'd2; width_q <= '0; height_q <= '0; fb_q <= '0;
      guest_q <= '0; cur_id_q <= '0; cursor_x <= '0; cursor_y <= '0; cursor_on <= 1'b0;
      disp_enable <= 1'b0; ring_config <= 1'b0; cfg_done <= 1'b0; cursor_evt <= 1'b0;
      rsp_valid <= 1'b0; rsp_rdata <= '0; rsp_bad <= 1'b0;
      for (int i = 0; i < SCRATCH_N; i++) scr_q[i] <= '0;
    end else begin
      cfg_done   <= 1'b0;
      cursor_evt <= 1'b0;
      rsp_valid  <= rd;
      rsp_bad    <= rd && psel == 2'd1 && !(known || in_pal || in_scr);
      rsp_rdata  <= !rd ? 32'd0 : (psel == 2'd0) ? index_q : (psel == 2'd1) ? val_mux : 32'd0;
      if (wr_idx) index_q <= req_wdata;
      if (wr_val) begin
        case (index_q)
          I_ID:    if (req_wdata == MAGIC || req_wdata == (MAGIC | 32'd1) || req_wdata == (MAGIC | 32'd2))
                     id_q <= req_wdata;
          I_EN:    begin
                     disp_enable <= |req_wdata;
                     ring_config <= ring_config & (|req_wdata);
                   end
          I_W:     width_q <= req_wdata;
          I_H:     height_q <= req_wdata;
          I_CFG:   begin
                     ring_config <= |req_wdata;
                     cfg_done    <= |req_wdata;
                   end
          I_GUEST: guest_q <= req_wdata;
          I_CID:   cur_id_q <= req_wdata;
          I_CX:    cursor_x <= req_wdata;
          I_CY:    cursor_y <= req_wdata;
          I_CON:   if (req_wdata <= 32'd1) begin
                     cursor_on  <= req_wdata[0];
                     cursor_evt <= 1'b1;
                   end
          default: if (in_scr) scr_q[sidx] <= req_wdata;
        endcase
        if (index_q == I_W || index_q == I_H || index_q == I_EN)
          fb_q <= BYPP32 * w_nxt * h_nxt;
      end
    end
  end
endmodule

module disp_regport_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [31:0] req_wdata,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic        rsp_bad,
  input logic        disp_enable,
  input logic        ring_config,
  input logic        cfg_done,
  input logic        cursor_evt,
  input logic        cursor_on,
  input logic [31:0] id_q
);
  p_id_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    id_q == 32'h9000_0000 || id_q == 32'h9000_0001 || id_q == 32'h9000_0002);
  p_disable_clears_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(disp_enable) |-> !ring_config);
  p_strobe_sets_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> ring_config);
  p_cursor_evt_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cursor_evt |-> cursor_on == ($past(req_wdata) == 32'd1));
  p_bad_reads_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_bad |-> rsp_rdata == 32'd0);
  p_read_latency_r13: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |=> rsp_valid);
  p_no_spurious_rsp_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
endmodule

bind disp_regport disp_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_bad(rsp_bad),
  .disp_enable(disp_enable), .ring_config(ring_config), .cfg_done(cfg_done),
  .cursor_evt(cursor_evt), .cursor_on(cursor_on), .id_q(id_q)
);

// File: tb/disp_regport_test.sv
module disp_regport_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, cursor_sink = 1'b0;
  logic [1:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_bad, disp_enable, ring_config, cfg_done, cursor_evt, cursor_on;
  logic [31:0] rsp_rdata, cursor_x, cursor_y;
  int checks = 0, failures = 0;
  logic last_cfg, last_evt;

  always #2 clk = ~clk;

  disp_regport uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .cursor_sink(cursor_sink), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_bad(rsp_bad), .disp_enable(disp_enable), .ring_config(ring_config),
    .cfg_done(cfg_done), .cursor_evt(cursor_evt), .cursor_on(cursor_on),
    .cursor_x(cursor_x), .cursor_y(cursor_y)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic port_wr(input logic [1:0] p, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = p; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    last_cfg = cfg_done; last_evt = cursor_evt;
  endtask

  task automatic port_rd(input logic [1:0] p, output logic [31:0] d, output logic bad, output logic vld);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = p;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata; bad = rsp_bad; vld = rsp_valid;
  endtask

  task automatic reg_wr(input logic [31:0] idx, input logic [31:0] v);
    port_wr(2'd0, idx);
    port_wr(2'd1, v);
  endtask

  task automatic reg_rd(input logic [31:0] idx, output logic [31:0] d, output logic bad);
    logic vld;
    port_wr(2'd0, idx);
    port_rd(2'd1, d, bad, vld);
  endtask

  task automatic t_reset;
    logic [31:0] d; logic b, v;
    chk("R1 enable", {31'd0, disp_enable}, 0);
    chk("R1 ring_config", {31'd0, ring_config}, 0);
    chk("R1 cursor_on", {31'd0, cursor_on}, 0);
    port_rd(2'd0, d, b, v);
    chk("R1 selector", d, 0);
    reg_rd(0, d, b);
    chk("R1 identity", d, 32'h9000_0002);
  endtask

  task automatic t_latency;
    logic [31:0] d; logic b, v;
    chk("R13 ready", {31'd0, req_ready}, 1);
    port_rd(2'd0, d, b, v);
    chk("R13 rsp_valid after read", {31'd0, v}, 1);
    @(negedge clk);
    chk("R13 rsp_valid one cycle only", {31'd0, rsp_valid}, 0);
  endtask

  task automatic t_id;
    logic [31:0] d; logic b;
    reg_wr(0, 32'h9000_0001); reg_rd(0, d, b); chk("R2 legal id 1", d, 32'h9000_0001);
    reg_wr(0, 32'h1234_5678); reg_rd(0, d, b); chk("R2 illegal id", d, 32'h9000_0001);
    reg_wr(0, 32'h9000_0003); reg_rd(0, d, b); chk("R2 id 3 rejected", d, 32'h9000_0001);
    reg_wr(0, 32'h9000_0000); reg_rd(0, d, b); chk("R2 legal id 0", d, 32'h9000_0000);
  endtask

  task automatic t_depth;
    logic [31:0] d; logic b;
    reg_rd(7, d, b);  chk("R3 bpp", d, 24);
    reg_rd(28, d, b); chk("R3 host bpp", d, 24);
    reg_wr(7, 16);
    reg_rd(7, d, b);  chk("R3 bpp after bad write", d, 24);
    reg_rd(28, d, b); chk("R3 host bpp after bad write", d, 24);
  endtask

  task automatic t_mode;
    logic [31:0] d; logic b;
    reg_wr(2, 640); reg_wr(3, 480);
    reg_rd(12, d, b); chk("R4 pitch 640", d, 1920);
    reg_rd(16, d, b); chk("R4 fb size 640x480", d, 921600);
    reg_wr(2, 800);
    reg_rd(12, d, b); chk("R4 pitch 800", d, 2400);
    reg_rd(16, d, b); chk("R4 fb size 800x480", d, 1152000);
  endtask

  task automatic t_limits;
    logic [31:0] d; logic b;
    reg_rd(4, d, b); chk("R5 max width", d, 2360);
    reg_rd(5, d, b); chk("R5 max height", d, 1770);
  endtask

  task automatic t_caps;
    logic [31:0] d; logic b;
    cursor_sink = 1'b0; reg_rd(17, d, b); chk("R6 caps no cursor", d, 32'h03);
    cursor_sink = 1'b1; reg_rd(17, d, b); chk("R6 caps cursor", d, 32'hE3);
    cursor_sink = 1'b0;
  endtask

  task automatic t_mem;
    logic [31:0] d; logic b;
    reg_rd(19, d, b); chk("R7 ring size", d, 32'h0001_0000);
    reg_rd(18, d, b); chk("R7 ring start", d, 32'hE0FF_0000);
    reg_rd(15, d, b); chk("R7 usable mem", d, 32'h00FF_0000);
  endtask

  task automatic t_cfgdone;
    reg_wr(20, 1);
    chk("R9 strobe", {31'd0, last_cfg}, 1);
    chk("R9 config set", {31'd0, ring_config}, 1);
    @(negedge clk);
    chk("R9 strobe one cycle", {31'd0, cfg_done}, 0);
    reg_wr(20, 0);
    chk("R9 no strobe on zero", {31'd0, last_cfg}, 0);
    chk("R9 config cleared", {31'd0, ring_config}, 0);
  endtask

  task automatic t_enable;
    reg_wr(20, 1);
    reg_wr(1, 1);
    chk("R8 enable set", {31'd0, disp_enable}, 1);
    chk("R8 config kept", {31'd0, ring_config}, 1);
    reg_wr(1, 0);
    chk("R8 enable cleared", {31'd0, disp_enable}, 0);
    chk("R8 config cleared", {31'd0, ring_config}, 0);
    reg_wr(1, 5);
    chk("R8 enable nonzero", {31'd0, disp_enable}, 1);
    chk("R8 config stays low", {31'd0, ring_config}, 0);
  endtask

  task automatic t_cursor;
    reg_wr(27, 1); chk("R10 show evt", {31'd0, last_evt}, 1); chk("R10 shown", {31'd0, cursor_on}, 1);
    reg_wr(27, 2); chk("R10 val2 no evt", {31'd0, last_evt}, 0); chk("R10 val2 keeps", {31'd0, cursor_on}, 1);
    reg_wr(27, 3); chk("R10 val3 no evt", {31'd0, last_evt}, 0); chk("R10 val3 keeps", {31'd0, cursor_on}, 1);
    reg_wr(27, 0); chk("R10 hide evt", {31'd0, last_evt}, 1); chk("R10 hidden", {31'd0, cursor_on}, 0);
    reg_wr(27, 3); chk("R10 val3 keeps off", {31'd0, cursor_on}, 0);
    reg_wr(25, 100); chk("R10 cursor x", cursor_x, 100);
  endtask

  task automatic t_scratch;
    logic [31:0] d; logic b;
    reg_rd(29, d, b); chk("R11 scratch count", d, 16);
    reg_wr(1792, 32'hAAAA_5555); reg_wr(1807, 32'h0000_1234);
    reg_rd(1792, d, b); chk("R11 scratch first", d, 32'hAAAA_5555);
    reg_rd(1807, d, b); chk("R11 scratch last", d, 32'h0000_1234);
    chk("R11 scratch not bad", {31'd0, b}, 0);
    reg_wr(23, 32'h5008); reg_rd(23, d, b); chk("R11 guest id", d, 32'h5008);
  endtask

  task automatic t_bad;
    logic [31:0] d; logic b, v;
    reg_rd(2000, d, b); chk("R12 far index data", d, 0); chk("R12 far index bad", {31'd0, b}, 1);
    reg_rd(1808, d, b); chk("R12 past scratch bad", {31'd0, b}, 1);
    reg_rd(50, d, b);   chk("R12 gap index bad", {31'd0, b}, 1);
    reg_rd(1100, d, b); chk("R12 palette data", d, 0); chk("R12 palette not bad", {31'd0, b}, 0);
    port_wr(2'd0, 2);
    port_wr(2'd2, 32'hFFFF_FFFF);
    port_rd(2'd2, d, b, v); chk("R12 firmware port reads zero", d, 0);
    port_rd(2'd0, d, b, v); chk("R12 firmware write keeps selector", d, 2);
    reg_rd(2, d, b); chk("R12 firmware write keeps width", d, 800);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_id();
    t_depth();
    t_mode();
    t_limits();
    t_caps();
    t_mem();
    t_cfgdone();
    t_enable();
    t_cursor();
    t_scratch();
    t_bad();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule